// File: doc/BRIEF.md
# Dual-Channel Edge Interrupt Controller

This block turns edges on a few monitored signals into interrupt requests. It has two independent channels. Each channel picks its trigger from one of three choices: one line of its own port, the AND of two lines of that port, or a timer or counter output. Each channel also picks whether rising or falling edges count. When the chosen signal makes the chosen transition, the channel sets a sticky pending flag. Software clears that flag by writing a 1 to its bit.

Everything is held in one 8-bit register. A write updates the channel settings and can clear flags. The read value always shows the current settings and the live flags. All six source inputs are asynchronous to the clock. They pass through a synchronizer chain of `SYNC_STAGES` flops before the edge detector looks at them. Either pending flag drives a shared request line and a matching external interrupt pin.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and both `irq_req` and `irq_pin` are 0.
- R2: The register has this layout, from bit 7 down to bit 0: flag 1, edge 1, mode 1 (two bits), flag 0, edge 0, mode 0 (two bits). A write loads the mode and edge bits, and they read back unchanged. The edge and mode bits do not change in any cycle without a write.
- R3: A channel whose mode is 00 never sets its flag, whatever its inputs do.
- R4: Mode 01 selects the channel's `line_lo` input. Mode 10 selects the AND of `line_lo` and `line_hi`. Mode 11 selects `ch0_timer` for channel 0 and `ch1_counter` for channel 1.
- R5: An edge bit of 1 makes the channel trigger on a 0-to-1 change of its selected signal. An edge bit of 0 makes it trigger on a 1-to-0 change.
- R6: The flag rises on exactly the (SYNC_STAGES+1)-th rising clock edge after the source input changes, and not on an earlier edge.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 leaves it as it was. A flag never falls without such a write.
- R8: A set flag stays set through any further edges. After it is cleared, it stays clear until a new qualifying edge arrives. Edges seen while the flag was set are not remembered.
- R9: If a clearing write lands in the same cycle that a new qualifying edge is detected, the flag stays set.
- R10: Both flags can be pending at once. `irq_req` is the OR of the two flags, and `irq_pin` always equals `irq_req`.
- R11: Changing a channel's mode or edge bit, with its inputs held steady, does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value, with live flags |
| ch0_line_lo | input | 1 | Channel 0 port line, used alone or in the AND |
| ch0_line_hi | input | 1 | Channel 0 second port line, used in the AND |
| ch0_timer | input | 1 | Channel 0 timer output source |
| ch1_line_lo | input | 1 | Channel 1 port line, used alone or in the AND |
| ch1_line_hi | input | 1 | Channel 1 second port line, used in the AND |
| ch1_counter | input | 1 | Channel 1 counter output source |
| irq_req | output | 1 | Combined interrupt request |
| irq_pin | output | 1 | External interrupt output pin |

## Verification
There are two timing rules.

A register write applied before a rising edge is visible on `rd_data` right after that edge. The bench drives each write at a falling edge and reads back at the next falling edge.

A source change reaches the flag after SYNC_STAGES+1 rising edges. The bench changes inputs at a falling edge and samples at the falling edge after SYNC_STAGES edges, where the flag must still be low. It samples again one edge later, where the flag must be set.

The same-cycle clear test places its write in the cycle in which the edge detector fires. That cycle is SYNC_STAGES edges after the input change.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ch0_line_lo,
  input  logic       ch0_line_hi,
  input  logic       ch0_timer,
  input  logic       ch1_line_lo,
  input  logic       ch1_line_hi,
  input  logic       ch1_counter,
  output logic       irq_req,
  output logic       irq_pin
);

  localparam int NCH   = 2;
  localparam int NSRC  = 3;
  localparam int FIELD = 4;
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [NCH*NSRC-1:0] raw;
  logic [NCH*NSRC-1:0] pipe [DEPTH];
  logic [NCH-1:0][1:0] mode;
  logic [NCH-1:0]      pol;
  logic [NCH-1:0]      flag;
  logic [NCH-1:0]      hit;

  assign raw = {ch1_counter, ch1_line_hi, ch1_line_lo,
                ch0_timer,   ch0_line_hi, ch0_line_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  function automatic logic pick(input logic [1:0] m, input logic [NSRC-1:0] s);
    case (m)
      2'b01:   pick = s[0];
      2'b10:   pick = s[0] & s[1];
      2'b11:   pick = s[2];
      default: pick = 1'b0;
    endcase
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NSRC-1:0] cur_s, prv_s;
    logic            cur_v, prv_v, clr;

    assign cur_s = pipe[SYNC_STAGES-1][c*NSRC +: NSRC];
    assign prv_s = pipe[SYNC_STAGES][c*NSRC +: NSRC];
    assign cur_v = pick(mode[c], cur_s);
    assign prv_v = pick(mode[c], prv_s);
    assign hit[c] = pol[c] ? (cur_v & ~prv_v) : (~cur_v & prv_v);
    assign clr = wr_en & wr_data[c*FIELD + 3];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode[c] <= 2'b00;
        pol[c]  <= 1'b0;
        flag[c] <= 1'b0;
      end else begin
        if (wr_en) begin
          mode[c] <= wr_data[c*FIELD +: 2];
          pol[c]  <= wr_data[c*FIELD + 2];
        end
        flag[c] <= hit[c] | (flag[c] & ~clr);
      end
    end

    assign rd_data[c*FIELD +: FIELD] = {flag[c], pol[c], mode[c]};
  end

  assign irq_req = |flag;
  assign irq_pin = irq_req;

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_req,
  input logic       irq_pin
);

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (rd_data == 8'h00 && !irq_req));

  // R7
  flag0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[3]) |-> $past(wr_en && wr_data[3]));

  // R7
  flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[7]) |-> $past(wr_en && wr_data[7]));

  // R8
  flag0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && !(wr_en && wr_data[3])) |=> rd_data[3]);

  // R8
  flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !(wr_en && wr_data[7])) |=> rd_data[7]);

  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (rd_data[3] | rd_data[7]));

  // R10
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_pin == irq_req);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({rd_data[6:4], rd_data[2:0]}));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({rd_data[6:4], rd_data[2:0]} == $past({wr_data[6:4], wr_data[2:0]})));

  // R3
  mode0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00 && !rd_data[3]) |=> !rd_data[3]);

  // R3
  mode1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b00 && !rd_data[7]) |=> !rd_data[7]);

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_req(irq_req), .irq_pin(irq_pin)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
  localparam int SYNC = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ch0_line_lo = 0, ch0_line_hi = 0, ch0_timer = 0;
  logic ch1_line_lo = 0, ch1_line_hi = 0, ch1_counter = 0;
  logic irq_req, irq_pin;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  edge_irq_ctrl #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ch0_line_lo(ch0_line_lo), .ch0_line_hi(ch0_line_hi), .ch0_timer(ch0_timer),
    .ch1_line_lo(ch1_line_lo), .ch1_line_hi(ch1_line_hi), .ch1_counter(ch1_counter),
    .irq_req(irq_req), .irq_pin(irq_pin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic set_src(input int ch, input logic [2:0] v);
    if (ch == 0) {ch0_timer, ch0_line_hi, ch0_line_lo} = v;
    else         {ch1_counter, ch1_line_hi, ch1_line_lo} = v;
  endtask

  function automatic logic sel(input logic [1:0] m, input logic [2:0] s);
    if (m == 2'd1) return s[0];
    if (m == 2'd2) return s[0] & s[1];
    if (m == 2'd3) return s[2];
    return 1'b0;
  endfunction

  function automatic logic [7:0] place(input int ch, input logic [3:0] f);
    return (ch == 0) ? {4'b0000, f} : {f, 4'b0000};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    step(3);
    check("R1 reset register", rd_data, 8'h00);
    check("R1 reset irq", {6'b0, irq_req, irq_pin}, 8'h00);
    rst_n = 1;
    step(2);

    // R3 R4 R5 R6 R10: sweep channel, mode, edge, start pattern, flipped input
    for (int ch = 0; ch < 2; ch++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int init = 0; init < 8; init++)
            for (int b = 0; b < 3; b++) begin
              logic [2:0] nv;
              logic so, sn, ev;
              logic [3:0] fld;
              set_src(ch, init[2:0]);
              set_src(1 - ch, 3'b000);
              step(SYNC + 2);
              fld = {1'b1, e[0], m[1:0]};
              wr(place(ch, fld) | place(1 - ch, 4'b1000));
              check("R2 R7 config readback after clear", rd_data, place(ch, {1'b0, e[0], m[1:0]}));
              nv = init[2:0] ^ (3'b001 << b);
              so = sel(m[1:0], init[2:0]);
              sn = sel(m[1:0], nv);
              ev = (m != 0) && (e[0] ? (!so && sn) : (so && !sn));
              set_src(ch, nv);
              step(SYNC);
              check("R6 no flag before latency", rd_data, place(ch, {1'b0, e[0], m[1:0]}));
              step(1);
              if (m == 0)
                check("R3 disabled channel", rd_data, place(ch, {1'b0, e[0], m[1:0]}));
              else
                check("R4 R5 flag from selected edge", rd_data, place(ch, {ev, e[0], m[1:0]}));
              check("R10 irq lines", {6'b0, irq_req, irq_pin}, {6'b0, ev, ev});
            end

    // R7: writing 0 keeps flag, writing 1 clears
    set_src(0, 3'b000); set_src(1, 3'b000);
    step(SYNC + 2);
    wr(8'h8D);
    set_src(0, 3'b001);
    step(SYNC + 1);
    check("R7 flag set", rd_data, 8'h0D);
    wr(8'h05);
    check("R7 write 0 keeps flag", rd_data, 8'h0D);
    check("R7 irq still up", {7'b0, irq_req}, 8'h01);

    // R8: further edges while set, then no memory after clear
    set_src(0, 3'b000); step(SYNC + 2);
    set_src(0, 3'b001); step(SYNC + 2);
    check("R8 flag sticky", rd_data, 8'h0D);
    wr(8'h0D);
    check("R7 write 1 clears", rd_data, 8'h05);
    step(SYNC + 4);
    check("R8 no queued interrupt", rd_data, 8'h05);
    check("R8 irq low", {6'b0, irq_req, irq_pin}, 8'h00);

    // R9: clear in the cycle the edge is detected
    set_src(0, 3'b000); step(SYNC + 2);
    wr(8'h0D);
    set_src(0, 3'b001);
    step(SYNC);
    wr(8'h0D);
    check("R9 same-cycle clear loses to edge", rd_data, 8'h0D);
    wr(8'h0D);
    check("R9 later clear works", rd_data, 8'h05);

    // R10: both pending, cleared one at a time
    set_src(0, 3'b000); set_src(1, 3'b100); step(SYNC + 2);
    wr(8'hB7);
    check("R10 config both", rd_data, 8'h37);
    set_src(0, 3'b100); set_src(1, 3'b000);
    step(SYNC + 1);
    check("R10 both pending", rd_data, 8'hBF);
    check("R10 irq both", {6'b0, irq_req, irq_pin}, 8'h03);
    wr(8'h3F);
    check("R10 one cleared", rd_data, 8'hB7);
    check("R10 irq with one left", {6'b0, irq_req, irq_pin}, 8'h03);
    wr(8'hB7);
    check("R10 irq after both clear", {6'b0, irq_req, irq_pin}, 8'h00);

    // R11: mode and edge changes with steady inputs
    set_src(0, 3'b001); set_src(1, 3'b111); step(SYNC + 2);
    wr(8'h88);
    wr(8'h01);
    step(SYNC + 2);
    check("R11 mode 00 to 01 on high line", rd_data, 8'h01);
    wr(8'h02);
    step(SYNC + 2);
    check("R11 mode 01 to 10 drops selection", rd_data, 8'h02);
    wr(8'h76);
    step(SYNC + 2);
    check("R11 edge and mode change", rd_data, 8'h76);

    finish_up();
  end
endmodule